// File: doc/BRIEF.md
# Delayed-Branch Fetch Address Sequencer

This block produces the fetch address for a simple in-order 64-bit core whose control transfers all have one branch delay slot. Each cycle it may retire the instruction at the current fetch address. A decoder supplies the kind of control transfer that instruction makes, the branch outcome, a target operand and a 16-bit-mode flag. The instruction right after any jump or branch always runs, and is flagged as sitting in a delay slot. A taken redirect reaches the fetch address only once that slot instruction has retired.

An exception or interrupt strobe overrides everything else in that cycle. The interrupted instruction does not retire, and fetch moves to a fixed vector. The restart address is saved in an exception PC register. When the interrupted instruction was in a delay slot, the saved address is the jump or branch before it, and a branch-delay output is raised. On restart the transfer is then decided again from live operands. A misaligned register-jump target does not fault at the jump. Instead an address-error flag is raised while that target is the fetch address.

Top module: `pc_seq`

## Requirements
- R1: While `rst_n` is low, `fetch_pc` equals parameter RESET_PC and `in_slot`, `addr_err`, `epc_bd` are 0 and `epc` is 0.
- R2: A retiring instruction that is not in a taken delay slot advances `fetch_pc` by 4 when `mode16`=0, or by 2 when `mode16`=1. With `insn_valid`=0 and no exception, all state holds.
- R3: Retiring any control transfer (`ctl_kind` nonzero) sets `in_slot` for the next instruction, which is at `fetch_pc` plus the step. A taken redirect is loaded into `fetch_pc` only when that slot instruction retires.
- R4: `ctl_kind`=1 (relative branch) redirects only when `br_taken`=1. Its target is the slot address plus `tgt_val[15:0]` sign-extended and shifted left by 2. When not taken, the slot is still flagged and fetch continues sequentially.
- R5: `ctl_kind`=2 (absolute jump) always redirects, to the slot address with bits 27:0 replaced by `{tgt_val[25:0], 2'b00}`.
- R6: `ctl_kind`=3 (register jump) always redirects, to `tgt_val` unchanged.
- R7: `link_we` is 1 when a retiring control transfer has `link_req`=1. `link_value` is then `fetch_pc`+8 in 32-bit mode, or +4 in 16-bit mode. `link_dst` is always 31.
- R8: An exception outside a delay slot loads `epc` with `fetch_pc` and clears `epc_bd`. It also sets `fetch_pc` to parameter VECTOR and clears `in_slot` and any pending redirect.
- R9: An exception while `in_slot`=1 loads `epc` with the address of the preceding control transfer and sets `epc_bd`.
- R10: `addr_err` is 1 exactly while `fetch_pc` holds an address with `fetch_pc[1:0]` nonzero (32-bit mode) or `fetch_pc[0]`=1 (16-bit mode). The mode is the `mode16` value in the cycle that address was loaded. `addr_err` stays 0 while the jump and its slot retire.
- R11: `exc_strobe` has priority over `insn_valid`: in that cycle nothing retires and `link_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction at `fetch_pc` retires this cycle |
| ctl_kind | input | 2 | 0 none, 1 relative branch, 2 absolute jump, 3 register jump |
| br_taken | input | 1 | Relative branch condition result |
| tgt_val | input | 64 | Offset, index or register value, depending on kind |
| link_req | input | 1 | Transfer writes a return link |
| mode16 | input | 1 | 16-bit instruction mode |
| exc_strobe | input | 1 | Exception or interrupt for the current instruction |
| fetch_pc | output | 64 | Current fetch address |
| in_slot | output | 1 | Current instruction is in a delay slot |
| addr_err | output | 1 | Current fetch address is misaligned |
| link_we | output | 1 | Return link write strobe |
| link_dst | output | 5 | Link destination register (31) |
| link_value | output | 64 | Return link address |
| epc | output | 64 | Saved restart address |
| epc_bd | output | 1 | Saved address is a jump or branch before a slot |

## Verification
On every cycle the assertions check several things. They check sequential advance and hold, that `in_slot` is set after each transfer, and that exceptions redirect to the vector and pick the right restart address according to `in_slot`. They also check that the address-error flag only accompanies a misaligned fetch address, and that an exception blocks link writes. The values of relative, absolute and register targets, and the arrival of the redirect exactly one instruction late, can only be shown by the bench scenarios. The same goes for dropping a pending redirect on an exception, 16-bit-mode alignment and the link address.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [1:0] {
    CT_NONE = 2'd0,
    CT_REL  = 2'd1,
    CT_ABS  = 2'd2,
    CT_REG  = 2'd3
  } ctl_kind_e;
endpackage

// File: rtl/pcseq_target.sv
module pcseq_target
  import pcseq_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int OFF_W = 16,
  parameter int IDX_W = 26
) (
  input  logic [1:0]      kind,
  input  logic            br_taken,
  input  logic [XLEN-1:0] tgt_val,
  input  logic [XLEN-1:0] slot_addr,
  output logic [XLEN-1:0] target,
  output logic            redirect
);
  localparam int SEXT_W = XLEN - OFF_W - 2;
  localparam int KEEP_W = XLEN - IDX_W - 2;

  logic [XLEN-1:0] rel_tgt;
  logic [XLEN-1:0] abs_tgt;

  assign rel_tgt = slot_addr + {{SEXT_W{tgt_val[OFF_W-1]}}, tgt_val[OFF_W-1:0], 2'b00};
  assign abs_tgt = {slot_addr[XLEN-1 -: KEEP_W], tgt_val[IDX_W-1:0], 2'b00};

  always_comb begin
    target   = tgt_val;
    redirect = 1'b0;
    unique case (ctl_kind_e'(kind))
      CT_NONE: begin target = slot_addr; redirect = 1'b0;     end
      CT_REL:  begin target = rel_tgt;   redirect = br_taken; end
      CT_ABS:  begin target = abs_tgt;   redirect = 1'b1;     end
      CT_REG:  begin target = tgt_val;   redirect = 1'b1;     end
      default: begin target = tgt_val;   redirect = 1'b0;     end
    endcase
  end
endmodule

// File: rtl/pcseq_align.sv
module pcseq_align #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] addr,
  input  logic            mode16,
  output logic            misaligned
);
  always_comb begin
    if (mode16) misaligned = addr[0];
    else        misaligned = |addr[1:0];
  end
endmodule

// File: rtl/pcseq_epc.sv
module pcseq_epc #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_exc,
  input  logic            xfer_retire,
  input  logic            cur_in_slot,
  input  logic [XLEN-1:0] cur_pc,
  output logic [XLEN-1:0] epc,
  output logic            epc_bd
);
  logic [XLEN-1:0] br_pc_q, br_pc_d;
  logic [XLEN-1:0] epc_q, epc_d;
  logic            bd_q, bd_d;
  logic            br_en, exc_en;

  assign br_en  = xfer_retire;
  assign exc_en = take_exc;

  always_comb begin
    br_pc_d = cur_pc;
    epc_d   = cur_in_slot ? br_pc_q : cur_pc;
    bd_d    = cur_in_slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_pc_q <= '0;
    end else if (br_en) begin
      br_pc_q <= br_pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q <= '0;
      bd_q  <= 1'b0;
    end else if (exc_en) begin
      epc_q <= epc_d;
      bd_q  <= bd_d;
    end
  end

  assign epc    = epc_q;
  assign epc_bd = bd_q;
endmodule

// File: rtl/pc_seq.sv
module pc_seq
  import pcseq_pkg::*;
#(
  parameter int          XLEN     = 64,
  parameter int          OFF_W    = 16,
  parameter int          IDX_W    = 26,
  parameter int          LINK_REG = 31,
  parameter logic [63:0] RESET_PC = 64'h0000_0000_0000_1000,
  parameter logic [63:0] VECTOR   = 64'h0000_0000_0000_0180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  input  logic [1:0]      ctl_kind,
  input  logic            br_taken,
  input  logic [XLEN-1:0] tgt_val,
  input  logic            link_req,
  input  logic            mode16,
  input  logic            exc_strobe,
  output logic [XLEN-1:0] fetch_pc,
  output logic            in_slot,
  output logic            addr_err,
  output logic            link_we,
  output logic [4:0]      link_dst,
  output logic [XLEN-1:0] link_value,
  output logic [XLEN-1:0] epc,
  output logic            epc_bd
);
  localparam logic [XLEN-1:0] STEP32 = XLEN'(4);
  localparam logic [XLEN-1:0] STEP16 = XLEN'(2);

  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] tgt_q, tgt_d;
  logic            slot_q, slot_d;
  logic            pend_q, pend_d;
  logic            err_q, err_d;
  logic            state_en;
  logic            retire;
  logic            is_xfer;
  logic [XLEN-1:0] step;
  logic [XLEN-1:0] slot_addr;
  logic [XLEN-1:0] new_tgt;
  logic            new_redirect;
  logic            pc_d_misaligned;

  assign retire    = insn_valid && !exc_strobe;
  assign is_xfer   = (ctl_kind_e'(ctl_kind) != CT_NONE);
  assign step      = mode16 ? STEP16 : STEP32;
  assign slot_addr = pc_q + step;
  assign state_en  = insn_valid || exc_strobe;

  pcseq_target #(
    .XLEN (XLEN),
    .OFF_W(OFF_W),
    .IDX_W(IDX_W)
  ) i_target (
    .kind     (ctl_kind),
    .br_taken (br_taken),
    .tgt_val  (tgt_val),
    .slot_addr(slot_addr),
    .target   (new_tgt),
    .redirect (new_redirect)
  );

  pcseq_align #(
    .XLEN(XLEN)
  ) i_align (
    .addr      (pc_d),
    .mode16    (mode16),
    .misaligned(pc_d_misaligned)
  );

  pcseq_epc #(
    .XLEN(XLEN)
  ) i_epc (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_exc   (exc_strobe),
    .xfer_retire(retire && is_xfer),
    .cur_in_slot(slot_q),
    .cur_pc     (pc_q),
    .epc        (epc),
    .epc_bd     (epc_bd)
  );

  always_comb begin
    pc_d   = pc_q;
    tgt_d  = tgt_q;
    slot_d = slot_q;
    pend_d = pend_q;
    if (exc_strobe) begin
      pc_d   = VECTOR[XLEN-1:0];
      slot_d = 1'b0;
      pend_d = 1'b0;
    end else if (insn_valid) begin
      pc_d   = pend_q ? tgt_q : slot_addr;
      slot_d = is_xfer;
      pend_d = is_xfer && new_redirect;
      if (is_xfer) tgt_d = new_tgt;
    end
    err_d = pc_d_misaligned;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC[XLEN-1:0];
      tgt_q  <= '0;
      slot_q <= 1'b0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (state_en) begin
      pc_q   <= pc_d;
      tgt_q  <= tgt_d;
      slot_q <= slot_d;
      pend_q <= pend_d;
      err_q  <= err_d;
    end
  end

  assign fetch_pc   = pc_q;
  assign in_slot    = slot_q;
  assign addr_err   = err_q;
  assign link_we    = retire && is_xfer && link_req;
  assign link_dst   = 5'(LINK_REG);
  assign link_value = pc_q + step + step;
endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
  parameter int          XLEN   = 64,
  parameter logic [63:0] VECTOR = 64'h180
) (
  input logic            clk,
  input logic            rst_n,
  input logic            insn_valid,
  input logic [1:0]      ctl_kind,
  input logic            mode16,
  input logic            exc_strobe,
  input logic [XLEN-1:0] fetch_pc,
  input logic            in_slot,
  input logic            addr_err,
  input logic            link_we,
  input logic [XLEN-1:0] epc,
  input logic            epc_bd
);
  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !exc_strobe && !in_slot) |=>
      (fetch_pc == $past(fetch_pc) + ($past(mode16) ? XLEN'(2) : XLEN'(4))));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!insn_valid && !exc_strobe) |=> ($stable(fetch_pc) && $stable(in_slot) && $stable(addr_err)));

  assert_slot_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !exc_strobe && ctl_kind != 2'd0) |=> in_slot);

  assert_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_strobe |=> (fetch_pc == VECTOR[XLEN-1:0] && !in_slot));

  assert_epc_plain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_strobe && !in_slot) |=> (epc == $past(fetch_pc) && !epc_bd));

  assert_epc_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_strobe && in_slot) |=> epc_bd);

  assert_err_only_misaligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (fetch_pc[1:0] != 2'b00));

  assert_exc_blocks_link_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_strobe |-> !link_we);
endmodule

bind pc_seq pcseq_chk #(.XLEN(XLEN), .VECTOR(VECTOR)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .insn_valid(insn_valid),
  .ctl_kind  (ctl_kind),
  .mode16    (mode16),
  .exc_strobe(exc_strobe),
  .fetch_pc  (fetch_pc),
  .in_slot   (in_slot),
  .addr_err  (addr_err),
  .link_we   (link_we),
  .epc       (epc),
  .epc_bd    (epc_bd)
);

// File: tb/test_pc_seq.sv
module test_pc_seq;
  localparam int          CLK_PERIOD = 10;
  localparam logic [63:0] RST_PC     = 64'h1000;
  localparam logic [63:0] VEC        = 64'h180;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_valid, br_taken, link_req, mode16, exc_strobe;
  logic [1:0]  ctl_kind;
  logic [63:0] tgt_val;
  logic [63:0] fetch_pc, link_value, epc;
  logic        in_slot, addr_err, link_we, epc_bd;
  logic [4:0]  link_dst;

  int n_tests = 0;
  int n_fail  = 0;
  string tag = "R1";

  // behavioural reference state
  logic [63:0] m_pc, m_tgt, m_bpc, m_epc;
  logic        m_slot, m_pend, m_err, m_bd;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_seq i_pc_seq (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .ctl_kind(ctl_kind),
    .br_taken(br_taken), .tgt_val(tgt_val), .link_req(link_req), .mode16(mode16),
    .exc_strobe(exc_strobe), .fetch_pc(fetch_pc), .in_slot(in_slot),
    .addr_err(addr_err), .link_we(link_we), .link_dst(link_dst),
    .link_value(link_value), .epc(epc), .epc_bd(epc_bd)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_regs();
    chk(tag, "fetch_pc", fetch_pc, m_pc);
    chk(tag, "in_slot", 64'(in_slot), 64'(m_slot));
    chk(tag, "addr_err", 64'(addr_err), 64'(m_err));
    chk(tag, "epc", epc, m_epc);
    chk(tag, "epc_bd", 64'(epc_bd), 64'(m_bd));
  endtask

  function automatic logic [63:0] stepv(input logic m16);
    return m16 ? 64'd2 : 64'd4;
  endfunction

  task automatic model_update();
    logic [63:0] nxt, slot_a, t;
    logic        go;
    if (exc_strobe) begin
      m_epc = m_slot ? m_bpc : m_pc;
      m_bd  = m_slot;
      m_pc  = VEC; m_slot = 0; m_pend = 0; m_err = 0;
    end else if (insn_valid) begin
      slot_a = m_pc + stepv(mode16);
      nxt = m_pend ? m_tgt : slot_a;
      m_pend = 0;
      if (ctl_kind != 0) begin
        m_bpc = m_pc;
        case (ctl_kind)
          2'd1: begin t = slot_a + (64'(signed'(tgt_val[15:0])) * 4); go = br_taken; end
          2'd2: begin t = {slot_a[63:28], tgt_val[25:0], 2'b00}; go = 1; end
          default: begin t = tgt_val; go = 1; end
        endcase
        m_tgt = t; m_pend = go; m_slot = 1;
      end else begin
        m_slot = 0;
      end
      m_pc  = nxt;
      m_err = mode16 ? nxt[0] : (nxt[1:0] != 0);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] k, input logic tk,
                      input logic [63:0] tv, input logic lk, input logic m16, input logic ex);
    logic        exp_we;
    logic [63:0] exp_lv;
    @(negedge clk);
    insn_valid = v; ctl_kind = k; br_taken = tk; tgt_val = tv;
    link_req = lk; mode16 = m16; exc_strobe = ex;
    #1;
    exp_we = v && !ex && (k != 0) && lk;
    chk(ex ? "R11" : "R7", "link_we", 64'(link_we), 64'(exp_we));
    chk("R7", "link_dst", 64'(link_dst), 64'd31);
    if (exp_we) begin
      exp_lv = m_pc + 2 * stepv(m16);
      chk("R7", "link_value", link_value, exp_lv);
    end
    @(posedge clk);
    model_update();
    #1;
    chk_regs();
  endtask

  initial begin
    rst_n = 0; insn_valid = 0; ctl_kind = 0; br_taken = 0; tgt_val = 0;
    link_req = 0; mode16 = 0; exc_strobe = 0;
    m_pc = RST_PC; m_tgt = 0; m_bpc = 0; m_epc = 0;
    m_slot = 0; m_pend = 0; m_err = 0; m_bd = 0;
    repeat (3) @(posedge clk);
    #1;
    tag = "R1"; chk_regs();
    @(negedge clk); rst_n = 1;

    tag = "R2";
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R2", "seq +4", fetch_pc, 64'h1004);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R2", "hold", fetch_pc, 64'h1004);

    tag = "R3";
    step(1, 1, 1, 64'h4, 0, 0, 0);
    chk("R3", "slot addr", fetch_pc, 64'h1008);
    chk("R3", "slot flag", 64'(in_slot), 64'd1);
    tag = "R4";
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R4", "rel target", fetch_pc, 64'h1018);

    step(1, 1, 0, 64'h100, 0, 0, 0);
    chk("R4", "untaken slot flag", 64'(in_slot), 64'd1);
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R4", "untaken seq", fetch_pc, 64'h1020);

    step(1, 1, 1, 64'hFFFF, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R4", "negative offset", fetch_pc, 64'h1020);

    tag = "R5";
    step(1, 2, 0, 64'h40, 1, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R5", "abs target", fetch_pc, 64'h100);

    tag = "R10";
    step(1, 3, 0, 64'h2002, 0, 0, 0);
    chk("R10", "no error at jump", 64'(addr_err), 64'd0);
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R6", "reg target", fetch_pc, 64'h2002);
    chk("R10", "misaligned 32", 64'(addr_err), 64'd1);

    tag = "R8";
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R8", "epc", epc, 64'h2002);
    chk("R8", "vector", fetch_pc, VEC);
    chk("R8", "epc_bd", 64'(epc_bd), 64'd0);

    tag = "R9";
    step(1, 1, 1, 64'h8, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R9", "epc branch", epc, 64'h180);
    chk("R9", "epc_bd", 64'(epc_bd), 64'd1);
    tag = "R8";
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R8", "pending dropped", fetch_pc, 64'h184);

    tag = "R2";
    step(1, 0, 0, 0, 0, 1, 0);
    chk("R2", "seq +2", fetch_pc, 64'h186);
    tag = "R7";
    step(1, 3, 0, 64'h3001, 1, 1, 0);
    tag = "R10";
    step(1, 0, 0, 0, 0, 1, 0);
    chk("R10", "misaligned 16", 64'(addr_err), 64'd1);
    step(1, 3, 0, 64'h3006, 0, 1, 0);
    step(1, 0, 0, 0, 0, 1, 0);
    chk("R10", "aligned 16", 64'(addr_err), 64'd0);

    tag = "R11";
    step(1, 3, 0, 64'h4000, 1, 0, 1);
    chk("R11", "no retire", fetch_pc, VEC);

    tag = "R6";
    for (int i = 0; i < 400; i++) begin
      logic [1:0] k;
      logic [63:0] tv;
      k  = m_slot ? 2'd0 : 2'($urandom_range(0, 3));
      tv = {$urandom(), $urandom()};
      step(1'($urandom_range(0, 4) != 0), k, 1'($urandom()), tv,
           1'($urandom()), 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 15) == 0));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule